// File: doc/BRIEF.md
# Shared-Counter Multi-Channel PWM Timer

This block is a small timer peripheral that produces several edge-aligned PWM waveforms from one time base. A single 16-bit up-counter, clocked through a power-of-two prescaler, runs from zero to a programmable modulo value and then wraps. Every channel compares that shared count with its own compare value. Each channel drives one output whose active level is chosen by a two-bit polarity field, or which is forced low when the channel is switched off. Since the counter is shared, all channels have the same period and differ only in duty and polarity.

Software drives the block through a 32-bit synchronous register port with a byte address. Read data appears one cycle after the address is presented. Modulo and compare values are double-buffered. While the counter is stopped a write lands at once. While it runs the write is parked and moved into the active register when the counter wraps, so a period never mixes old and new settings. Reads return the active value, which lets software poll until a parked update has landed. A per-channel match flag records that the count reached the compare value.

Top module: `pwm_tmr_top`

## Requirements
- R1: The register at byte offset 0x04 returns the number of channels in bits [7:0]. Any address with no register behind it (including 0x00, 0x08 and channel slots beyond the last channel) reads as 0. `rdata` holds the value for the address presented in the previous cycle.
- R2: The control register at 0x10 holds the prescale value in bits [2:0] and the clock mode in bits [4:3], and reads back both fields; bit 5 is ignored and reads 0. With a clock mode other than 0, the counter advances once every 2^prescale clocks. With clock mode 0, it holds its value.
- R3: The counter at 0x14 counts from 0 up to the active modulo value and wraps to 0 on the next advance, giving a period of modulo+1 advances.
- R4: Any write to the counter register at 0x14 sets the count to 0, whether the counter is stopped or running.
- R5: With clock mode 0, a write to the modulo register at 0x18, or to the compare register of channel n at 0x24+8n, takes effect at once and reads back on the following access. Only bits [15:0] are stored.
- R6: With a non-zero clock mode, a modulo or compare write does not change the value read back until the counter wraps. After the wrap the new value reads back and is in use.
- R7: The channel control register at 0x20+8n holds mode-select B in bit 5, mode-select A in bit 4 and the polarity field in bits [3:2]. With bit 5 set and polarity 2'b10, the channel output is high while the count is below the active compare value and low otherwise.
- R8: Polarity 2'b01 gives the complement of the R7 output. The reserved value 2'b11 behaves like 2'b10. Mode-select A has no effect on the output.
- R9: Polarity 2'b00, or mode-select B clear, drives the output low. A change of the polarity field reaches the output in the cycle after the write, without waiting for a wrap.
- R10: A compare value of 0 keeps an enabled channel inactive for the whole period. A compare value above the modulo value keeps it active for the whole period.
- R11: The channel flag, read in bit 7 of the channel control register, sets when the counter advances from a count equal to the active compare value. Writing 1 to bit 7 clears it, and writing 0 to bit 7 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe for the current cycle |
| addr | input | ADDR_W | Byte address of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the address of the previous cycle |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The assertions assume the counter register is written only through the port and that a write to the modulo register while running is parked, not applied. On that basis they check that the count only steps by one, wraps to zero or is cleared, and that the active modulo stays put between wraps while running. They also assume a prescaler tick never occurs while the clock mode is 0. The stimulus keeps the modulo value well below the 16-bit limit and makes every configuration change while the counter is stopped, except in the scenarios that test deferred updates and immediate polarity changes. Those scenarios time each write against a known count, so every wrap falls on a predicted cycle.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int PS_W   = 3;
  localparam int PRE_W  = (1 << PS_W) - 1;

  localparam int OFS_PARAM     = 'h04;
  localparam int OFS_CTRL      = 'h10;
  localparam int OFS_CNT       = 'h14;
  localparam int OFS_MOD       = 'h18;
  localparam int OFS_CH_BASE   = 'h20;
  localparam int OFS_CH_STRIDE = 8;
  localparam int OFS_CH_CMP    = 4;

  typedef enum logic [1:0] {
    POL_OFF  = 2'b00,
    POL_INV  = 2'b01,
    POL_NORM = 2'b10,
    POL_RSV  = 2'b11
  } pol_t;

  typedef struct packed {
    logic msb;
    logic msa;
    pol_t pol;
  } chan_cfg_t;

  // prescaler fires when the low 'ps' bits of the divider are all ones
  function automatic logic ps_tick(input logic [PRE_W-1:0] pre,
                                   input logic [PS_W-1:0] ps);
    logic [PRE_W-1:0] mask;
    mask = PRE_W'((1 << ps) - 1);
    return (pre & mask) == mask;
  endfunction

  // edge-aligned level for one channel
  function automatic logic pwm_level(input chan_cfg_t cfg,
                                     input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] cmp);
    logic active;
    active = cnt < cmp;
    if (!cfg.msb || cfg.pol == POL_OFF) return 1'b0;
    if (cfg.pol == POL_INV) return !active;
    return active;
  endfunction

  function automatic logic [DATA_W-1:0] cfg_word(input logic flag,
                                                 input chan_cfg_t cfg);
    return {24'b0, flag, 1'b0, cfg.msb, cfg.msa, cfg.pol, 2'b00};
  endfunction

endpackage

// File: rtl/pwm_tmr_prescale.sv
module pwm_tmr_prescale
  import pwm_tmr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               pre_q <= '0;
    else if (!run || restart) pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;
  end

  assign tick = run && ps_tick(pre_q, ps);

endmodule

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter
  import pwm_tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             cnt_clr,
  input  logic             mod_we,
  input  logic [CNT_W-1:0] mod_wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] mod_act,
  output logic             wrap
);

  logic [CNT_W-1:0] mod_buf;

  // >= keeps the count bounded if the modulo was lowered while stopped
  assign wrap = tick && (cnt >= mod_act);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (cnt_clr) cnt <= '0;
    else if (wrap)    cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mod_buf <= '0;
      mod_act <= '0;
    end else begin
      if (mod_we) mod_buf <= mod_wdata;
      if (mod_we && !run) mod_act <= mod_wdata;
      else if (wrap)      mod_act <= mod_buf;
    end
  end

endmodule

// File: rtl/pwm_tmr_channel.sv
module pwm_tmr_channel
  import pwm_tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  output chan_cfg_t        cfg,
  output logic             flag,
  output logic [CNT_W-1:0] cmp_act,
  output logic             pwm
);

  logic [CNT_W-1:0] cmp_buf;
  logic             hit;

  assign hit = tick && (cnt == cmp_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (cfg_we) begin
      cfg.msb <= cfg_wdata[5];
      cfg.msa <= cfg_wdata[4];
      cfg.pol <= pol_t'(cfg_wdata[3:2]);
    end
  end

  // a new match wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rst_n)                      flag <= 1'b0;
    else if (hit)                    flag <= 1'b1;
    else if (cfg_we && cfg_wdata[7]) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_buf <= '0;
      cmp_act <= '0;
    end else begin
      if (cmp_we) cmp_buf <= cmp_wdata;
      if (cmp_we && !run) cmp_act <= cmp_wdata;
      else if (wrap)      cmp_act <= cmp_buf;
    end
  end

  assign pwm = pwm_level(cfg, cnt, cmp_act);

endmodule

// File: rtl/pwm_tmr_top.sv
module pwm_tmr_top
  import pwm_tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  localparam logic [ADDR_W-1:0] A_PARAM = ADDR_W'(OFS_PARAM);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(OFS_CNT);
  localparam logic [ADDR_W-1:0] A_MOD   = ADDR_W'(OFS_MOD);

  logic [PS_W-1:0]  ctl_ps;
  logic [1:0]       ctl_mode;
  logic             run;
  logic             pre_tick;
  logic             period_wrap;
  logic             cnt_clr;
  logic             mod_we;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mod_act;
  logic [DATA_W-1:0] rd_next;

  chan_cfg_t        ch_cfg [NUM_CH];
  logic [CNT_W-1:0] ch_cmp [NUM_CH];
  logic [NUM_CH-1:0] ch_flag;

  logic unused_wdata;
  assign unused_wdata = ^wdata[DATA_W-1:CNT_W];

  assign run     = ctl_mode != 2'b00;
  assign cnt_clr = wr_en && (addr == A_CNT);
  assign mod_we  = wr_en && (addr == A_MOD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_ps   <= '0;
      ctl_mode <= '0;
    end else if (wr_en && addr == A_CTRL) begin
      ctl_ps   <= wdata[PS_W-1:0];
      ctl_mode <= wdata[PS_W+1:PS_W];
    end
  end

  pwm_tmr_prescale u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (cnt_clr),
    .ps      (ctl_ps),
    .tick    (pre_tick)
  );

  pwm_tmr_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (pre_tick),
    .cnt_clr   (cnt_clr),
    .mod_we    (mod_we),
    .mod_wdata (wdata[CNT_W-1:0]),
    .cnt       (cnt_q),
    .mod_act   (mod_act),
    .wrap      (period_wrap)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CH_BASE + OFS_CH_STRIDE * g);
    localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(OFS_CH_BASE + OFS_CH_STRIDE * g + OFS_CH_CMP);

    pwm_tmr_channel u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .tick      (pre_tick),
      .wrap      (period_wrap),
      .cnt       (cnt_q),
      .cfg_we    (wr_en && addr == A_CFG),
      .cfg_wdata (wdata[7:0]),
      .cmp_we    (wr_en && addr == A_CMP),
      .cmp_wdata (wdata[CNT_W-1:0]),
      .cfg       (ch_cfg[g]),
      .flag      (ch_flag[g]),
      .cmp_act   (ch_cmp[g]),
      .pwm       (pwm_out[g])
    );
  end

  always_comb begin
    rd_next = '0;
    if (addr == A_PARAM) rd_next[7:0] = 8'(NUM_CH);
    if (addr == A_CTRL)  rd_next[PS_W+1:0] = {ctl_mode, ctl_ps};
    if (addr == A_CNT)   rd_next[CNT_W-1:0] = cnt_q;
    if (addr == A_MOD)   rd_next[CNT_W-1:0] = mod_act;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(OFS_CH_BASE + OFS_CH_STRIDE * i))
        rd_next = cfg_word(ch_flag[i], ch_cfg[i]);
      if (addr == ADDR_W'(OFS_CH_BASE + OFS_CH_STRIDE * i + OFS_CH_CMP))
        rd_next = DATA_W'(ch_cmp[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_next;
  end

endmodule

// File: rtl/pwm_tmr_chk.sv
module pwm_tmr_chk
  import pwm_tmr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic             wrap,
  input logic             cnt_clr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] mod_act
);

  a_r2_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);

  a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_clr) |=> $stable(cnt));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap && !cnt_clr) |=> (cnt == $past(cnt) + 1'b1));

  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt == '0));

  a_r6_mod_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(mod_act));

endmodule

bind pwm_tmr_top pwm_tmr_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run),
  .tick    (pre_tick),
  .wrap    (period_wrap),
  .cnt_clr (cnt_clr),
  .cnt     (cnt_q),
  .mod_act (mod_act)
);

// File: tb/pwm_tmr_top_tb_top.sv
module pwm_tmr_top_tb_top;

  localparam int NCH = 4;

  localparam logic [7:0] A_PARAM = 8'h04;
  localparam logic [7:0] A_CTRL  = 8'h10;
  localparam logic [7:0] A_CNT   = 8'h14;
  localparam logic [7:0] A_MOD   = 8'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] pwm_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] tb_cfg [NCH];
  logic [15:0] tb_cmp [NCH];

  always #2 clk = ~clk;

  pwm_tmr_top #(.NUM_CH(NCH), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  function automatic logic [7:0] a_cfg(input int n);
    return 8'(8'h20 + 8 * n);
  endfunction

  function automatic logic [7:0] a_cmp(input int n);
    return 8'(8'h24 + 8 * n);
  endfunction

  // expected level from the requirement text, not the RTL
  function automatic logic model_out(input logic [31:0] c, input int cnt, input int cmp);
    logic on;
    logic [1:0] pol;
    pol = c[3:2];
    on = cnt < cmp;
    if (c[5] == 1'b0 || pol == 2'b00) return 1'b0;
    if (pol == 2'b01) return !on;
    return on;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    wr_en = 1'b0; addr = a;
    @(posedge clk); @(negedge clk);
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ch(input int n, input logic [31:0] c, input logic [15:0] cmp);
    tb_cfg[n] = c; tb_cmp[n] = cmp;
    wr(a_cfg(n), c | 32'h80);
    wr(a_cmp(n), {16'h0, cmp});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R9 outputs low after reset", {28'h0, pwm_out}, 32'h0);
    rd(A_CNT, d); chk("R3 count after reset", d, 0);
    rd(A_MOD, d); chk("R5 modulo after reset", d, 0);
  endtask

  task automatic t_decode();
    logic [31:0] d;
    rd(A_PARAM, d); chk("R1 channel count", d, NCH);
    rd(8'h00, d);   chk("R1 unmapped 0x00", d, 0);
    rd(8'h08, d);   chk("R1 unmapped 0x08", d, 0);
    rd(a_cfg(NCH), d); chk("R1 absent channel", d, 0);
    wr(A_CTRL, 32'h25);
    rd(A_CTRL, d);  chk("R2 control readback", d, 32'h05);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_prescale();
    logic [31:0] d;
    wr(A_MOD, 100); wr(A_CNT, 0);
    wr(A_CTRL, 32'h0A); idle(9); wr(A_CTRL, 0);
    rd(A_CNT, d); chk("R2 prescale 4", d, 2);
    idle(3);
    rd(A_CNT, d); chk("R2 hold when stopped", d, 2);
    wr(A_CNT, 0); wr(A_CTRL, 32'h08); idle(4); wr(A_CTRL, 0);
    rd(A_CNT, d); chk("R2 prescale 1", d, 5);
    wr(A_CNT, 0); wr(A_CTRL, 32'h0F); idle(300); wr(A_CTRL, 0);
    rd(A_CNT, d); chk("R2 prescale 128", d, 2);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    wr(A_MOD, 4); wr(A_CNT, 0);
    wr(A_CTRL, 32'h08); idle(3); wr(A_CTRL, 0);
    rd(A_CNT, d); chk("R3 reaches modulo", d, 4);
    wr(A_CNT, 0); wr(A_CTRL, 32'h08); idle(6); wr(A_CTRL, 0);
    rd(A_CNT, d); chk("R3 wrapped once", d, 2);
    wr(A_CNT, 0); wr(A_CTRL, 32'h09); idle(20); wr(A_CTRL, 0);
    rd(A_CNT, d); chk("R3 wrap with prescale", d, 0);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(A_CNT, 0); wr(A_CTRL, 32'h08); idle(6); wr(A_CTRL, 0);
    wr(A_CNT, 32'h1234);
    rd(A_CNT, d); chk("R4 clear when stopped", d, 0);
    wr(A_CTRL, 32'h08); idle(3); wr(A_CNT, 0); wr(A_CTRL, 0);
    rd(A_CNT, d); chk("R4 clear when running", d, 1);
  endtask

  task automatic t_stopped_update();
    logic [31:0] d;
    wr(A_MOD, 32'hABCD_0007);
    rd(A_MOD, d); chk("R5 modulo lands at once", d, 7);
    wr(a_cmp(2), 32'h1234);
    rd(a_cmp(2), d); chk("R5 compare lands at once", d, 32'h1234);
  endtask

  task automatic t_running_update();
    logic [31:0] d;
    wr(A_MOD, 4); wr(A_CNT, 0); wr(a_cmp(0), 2);
    wr(A_CTRL, 32'h08);
    wr(A_MOD, 9); wr(a_cmp(0), 6);
    rd(A_MOD, d);    chk("R6 modulo held", d, 4);
    rd(a_cmp(0), d); chk("R6 compare held", d, 2);
    idle(2);
    rd(A_MOD, d);    chk("R6 modulo after wrap", d, 9);
    rd(a_cmp(0), d); chk("R6 compare after wrap", d, 6);
    wr(A_CTRL, 0);
  endtask

  task automatic run_pattern(input string req, input int modv, input int cycles);
    logic [NCH-1:0] exp;
    wr(A_MOD, modv); wr(A_CNT, 0);
    wr(A_CTRL, 32'h08);
    for (int k = 0; k < cycles; k++) begin
      for (int n = 0; n < NCH; n++)
        exp[n] = model_out(tb_cfg[n], k % (modv + 1), int'(tb_cmp[n]));
      chk(req, {28'h0, pwm_out}, {28'h0, exp});
      idle(1);
    end
    wr(A_CTRL, 0);
  endtask

  task automatic t_outputs();
    set_ch(0, 32'h28, 3);
    set_ch(1, 32'h24, 3);
    set_ch(2, 32'h2C, 5);
    set_ch(3, 32'h28, 0);
    run_pattern("R7 R8 R10 polarity and zero compare", 9, 25);
    set_ch(0, 32'h38, 3);
    set_ch(1, 32'h08, 3);
    set_ch(2, 32'h00, 5);
    set_ch(3, 32'h28, 12);
    run_pattern("R8 R9 R10 mode bits and full compare", 9, 20);
  endtask

  task automatic t_immediate();
    wr(A_MOD, 1000); wr(A_CNT, 0);
    set_ch(0, 32'h28, 1000);
    wr(A_CTRL, 32'h08);
    chk("R9 enabled before change", {31'h0, pwm_out[0]}, 1);
    wr(a_cfg(0), 32'h20);
    chk("R9 off takes effect at once", {31'h0, pwm_out[0]}, 0);
    wr(a_cfg(0), 32'h28);
    chk("R9 normal takes effect at once", {31'h0, pwm_out[0]}, 1);
    wr(a_cfg(0), 32'h24);
    chk("R9 inverted takes effect at once", {31'h0, pwm_out[0]}, 0);
    wr(A_CTRL, 0);
  endtask

  task automatic t_flag();
    logic [31:0] d;
    wr(A_MOD, 9); wr(A_CNT, 0);
    set_ch(0, 32'h28, 3);
    set_ch(1, 32'h28, 8);
    rd(a_cfg(0), d); chk("R11 flag clear before run", d, 32'h28);
    wr(A_CTRL, 32'h08); idle(4); wr(A_CTRL, 0);
    rd(a_cfg(0), d); chk("R11 flag set on match", d, 32'hA8);
    rd(a_cfg(1), d); chk("R11 no flag without match", d, 32'h28);
    wr(a_cfg(0), 32'h28);
    rd(a_cfg(0), d); chk("R11 write 0 keeps flag", d, 32'hA8);
    wr(a_cfg(0), 32'hA8);
    rd(a_cfg(0), d); chk("R11 write 1 clears flag", d, 32'h28);
  endtask

  task automatic finish_sim();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_decode();
    t_prescale();
    t_wrap();
    t_clear();
    t_stopped_update();
    t_running_update();
    t_outputs();
    t_immediate();
    t_flag();
    done = 1'b1;
    finish_sim();
  end

  initial begin
    #(4 * 50000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
    end
  end

endmodule